// File: doc/BRIEF.md
# Store Queue with Commit, Writeback and Retirement

The block is a circular buffer of executed stores. A store enters at the tail with a sequence number, a byte size, an address and data. A commit request makes every store from the oldest onward eligible for writeback, up to the youngest sequence number that has been retired by the pipeline. The writeback engine has its own pointer, separate from the head. It presents eligible stores one at a time to memory over a valid/ready channel that carries the slot index. When memory reports completion of a slot, entries leave the queue from the head.

Zero-size stores are eligible but never reach memory: they complete as soon as the writeback pointer reaches them. The head only moves across an unbroken run of completed entries, so stores that complete out of order are held until everything older has completed. A squash trims younger, uncommitted stores from the tail and stops at the first committed store. The block also reports how many instructions the surrounding queues can still accept: the smaller of the free load-queue and free store-queue counts, less the spare slot.

Sequence numbers are compared as plain unsigned values without wrap. Memory returns a completion only for a slot index it has accepted, and returns it once.

Top module: `store_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `free_slots` equals DEPTH (4 by default) when `lq_used` is 0, and `mem_req_valid` is 0.
- R2: Each accepted allocation lowers `free_slots` by one from the next cycle. An allocation offered while DEPTH stores are held is ignored, and `free_slots` stays 0.
- R3: A commit scans from the oldest store. It marks each unmarked store whose sequence number is at most `commit_seq`, and stops at the first unmarked store whose number is greater. Unmarked stores are never requested.
- R4: Eligible stores with nonzero size are requested in queue order, one per cycle, starting the cycle after they become eligible. `mem_req_idx` is the slot index (slot = allocation order modulo DEPTH+1, starting at 0 after reset), and the request carries that store's address, data and size.
- R5: A request that is refused (`mem_req_valid`=1, `mem_req_ready`=0) stays presented with the same index and address until it is accepted. The next store is presented in the cycle after acceptance.
- R6: An eligible store of size 0 completes without any request. It is skipped in one cycle, so the following store can be requested one cycle later.
- R7: A completion marks its slot done. The head moves past every consecutive done entry in the same cycle, so `free_slots` rises by the length of that run on the next cycle. A done entry behind an incomplete head frees nothing.
- R8: A squash removes stores from the tail backward while their sequence number is greater than `squash_seq`. It stops at the first committed store. Removed stores are never requested, and `free_slots` rises by the number removed.
- R9: A store committed in the same cycle as a squash counts as committed for that squash, so it survives.
- R10: `free_slots` = min(LQ_DEPTH+1 − `lq_used`, DEPTH+1 − stores held) − 1. The default LQ_DEPTH is 6.
- R11: An allocation offered in a cycle with `squash_valid`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Insert a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_size | input | SIZE_W | Byte size; 0 means no memory access |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_req_valid | output | 1 | Write request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_idx | output | IDX_W | Slot index of the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_data | output | DATA_W | Request data |
| mem_req_size | output | SIZE_W | Request size |
| mem_cpl_valid | input | 1 | Memory completion |
| mem_cpl_idx | input | IDX_W | Slot index being completed |
| lq_used | input | LQ_CNT_W | Entries held by the companion load queue |
| free_slots | output | FREE_W | Instructions the two queues can still take |

## Verification
Commit and squash can land in the same cycle. The bench issues both together: a commit that reaches the older of two uncommitted stores, and a squash number below both. Only the younger store should be removed. This is judged by `free_slots` rising by exactly one and by the surviving slot being requested on the next cycle while the removed slot never is. A completion at the head and a zero-size skip also meet in one head-run retirement. `free_slots` is expected to jump by two in a single cycle there.

// File: rtl/sq_pkg.sv
// Package: index arithmetic shared by the store queue and its scanners.
// Assumes operands already lie in [0, n) and offsets in [0, n].
package sq_pkg;

    // Add an offset to a ring index of size n.
    function automatic int ring_add(int a, int b, int n);
        int s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

    // Subtract an offset from a ring index of size n.
    function automatic int ring_sub(int a, int b, int n);
        int s;
        s = a - b;
        return (s < 0) ? s + n : s;
    endfunction

endpackage

// File: rtl/sq_commit_scan.sv
// Commit scanner: walks from the head over the occupied entries and marks
// every not-yet-eligible store up to the first unmarked one that is younger
// than the committed sequence number. Purely combinational.
module sq_commit_scan #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                        en,
    input  logic [SEQ_W-1:0]            youngest,
    input  logic [IDX_W-1:0]            head,
    input  logic [CNT_W-1:0]            count,
    input  logic [SLOTS-1:0]            elig,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
    output logic [SLOTS-1:0]            mark,
    output logic [CNT_W-1:0]            mark_cnt
);

    // Oldest-first walk that stops at the first uncommittable store.
    always_comb begin
        int  idx;
        int  n;
        logic stop;
        mark = '0;
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            idx = sq_pkg::ring_add(int'(head), i, SLOTS);
            if (en && !stop && i < int'(count) && !elig[idx]) begin
                if (seq[idx] > youngest) begin
                    stop = 1'b1;
                end else begin
                    mark[idx] = 1'b1;
                    n = n + 1;
                end
            end
        end
        mark_cnt = CNT_W'(n);
    end

endmodule

// File: rtl/sq_squash_scan.sv
// Squash scanner: walks backward from the tail and counts how many younger,
// uncommitted stores are removed. Stops at the first committed store or at
// the first store not younger than the squash number. Combinational.
module sq_squash_scan #(
    parameter int SLOTS = 5,
    parameter int SEQ_W = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                        en,
    input  logic [SEQ_W-1:0]            squash_seq,
    input  logic [IDX_W-1:0]            tail,
    input  logic [CNT_W-1:0]            count,
    input  logic [SLOTS-1:0]            elig,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
    output logic [CNT_W-1:0]            kill_cnt
);

    // Youngest-first walk over the occupied entries.
    always_comb begin
        int  idx;
        int  n;
        logic stop;
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            idx = sq_pkg::ring_sub(int'(tail), i + 1, SLOTS);
            if (en && !stop && i < int'(count)) begin
                if (elig[idx] || seq[idx] <= squash_seq) begin
                    stop = 1'b1;
                end else begin
                    n = n + 1;
                end
            end
        end
        kill_cnt = CNT_W'(n);
    end

endmodule

// File: rtl/sq_retire_scan.sv
// Retire scanner: measures the run of completed entries starting at the head.
// The done vector given already includes completions of the current cycle.
module sq_retire_scan #(
    parameter int SLOTS = 5,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [SLOTS-1:0] done_now,
    output logic [SLOTS-1:0] ret_vec,
    output logic [CNT_W-1:0] ret_cnt
);

    // Head-first walk that stops at the first incomplete entry.
    always_comb begin
        int  idx;
        int  n;
        logic stop;
        ret_vec = '0;
        n       = 0;
        stop    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            idx = sq_pkg::ring_add(int'(head), i, SLOTS);
            if (!stop && i < int'(count)) begin
                if (done_now[idx]) begin
                    ret_vec[idx] = 1'b1;
                    n = n + 1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
        ret_cnt = CNT_W'(n);
    end

endmodule

// File: rtl/store_queue.sv
// Store queue: circular buffer of DEPTH stores plus one spare slot. It holds
// three pointers (head, tail, writeback). Commit marks stores eligible, the
// writeback engine sends eligible stores to memory one per cycle over a
// valid/ready channel, completions retire a run of done entries from the
// head, and a squash trims uncommitted stores from the tail.
// Assumes: completions arrive only for accepted slots, at most one per cycle;
// sequence numbers do not wrap; lq_used never exceeds LQ_DEPTH.
module store_queue #(
    parameter int DEPTH    = 4,
    parameter int LQ_DEPTH = 6,
    parameter int SEQ_W    = 8,
    parameter int SIZE_W   = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    localparam int SLOTS    = DEPTH + 1,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int CNT_W    = $clog2(SLOTS + 1),
    localparam int LQ_CNT_W = $clog2(LQ_DEPTH + 2),
    localparam int MAXD     = (DEPTH > LQ_DEPTH) ? DEPTH : LQ_DEPTH,
    localparam int FREE_W   = $clog2(MAXD + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic [SIZE_W-1:0]   alloc_size,
    input  logic [ADDR_W-1:0]   alloc_addr,
    input  logic [DATA_W-1:0]   alloc_data,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [IDX_W-1:0]    mem_req_idx,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_data,
    output logic [SIZE_W-1:0]   mem_req_size,
    input  logic                mem_cpl_valid,
    input  logic [IDX_W-1:0]    mem_cpl_idx,
    input  logic [LQ_CNT_W-1:0] lq_used,
    output logic [FREE_W-1:0]   free_slots
);

    logic [IDX_W-1:0] head_q, tail_q, wb_q;
    logic [CNT_W-1:0] count_q, pend_q;
    logic [SLOTS-1:0] elig_q, done_q;
    logic [SLOTS-1:0][SEQ_W-1:0] seq_q;
    logic [SIZE_W-1:0] size_q [SLOTS];
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];

    logic [SLOTS-1:0] mark, elig_after, cpl_hit, zero_hit, done_now, ret_vec;
    logic [CNT_W-1:0] mark_cnt, kill_cnt, ret_cnt;
    logic             wb_ok, zero_done, accept, alloc_go;

    // Admission: no allocation when full or during a squash.
    assign alloc_go = alloc_valid && !squash_valid && (int'(count_q) < DEPTH);

    // Writeback candidate at the writeback pointer.
    assign wb_ok         = (pend_q != '0) && (wb_q != tail_q) && elig_q[wb_q];
    assign zero_done     = wb_ok && (size_q[wb_q] == '0);
    assign mem_req_valid = wb_ok && (size_q[wb_q] != '0);
    assign accept        = mem_req_valid && mem_req_ready;
    assign mem_req_idx   = wb_q;
    assign mem_req_addr  = addr_q[wb_q];
    assign mem_req_data  = data_q[wb_q];
    assign mem_req_size  = size_q[wb_q];

    sq_commit_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_commit (
        .en(commit_valid), .youngest(commit_seq), .head(head_q),
        .count(count_q), .elig(elig_q), .seq(seq_q),
        .mark(mark), .mark_cnt(mark_cnt)
    );

    // Eligibility as the squash must see it, including this cycle's commit.
    assign elig_after = elig_q | mark;

    sq_squash_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_squash (
        .en(squash_valid), .squash_seq(squash_seq), .tail(tail_q),
        .count(count_q), .elig(elig_after), .seq(seq_q),
        .kill_cnt(kill_cnt)
    );

    // One-hot completion sources of the current cycle.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            cpl_hit[s]  = mem_cpl_valid && (int'(mem_cpl_idx) == s);
            zero_hit[s] = zero_done && (int'(wb_q) == s);
        end
    end

    assign done_now = done_q | cpl_hit | zero_hit;

    sq_retire_scan #(.SLOTS(SLOTS)) u_retire (
        .head(head_q), .count(count_q), .done_now(done_now),
        .ret_vec(ret_vec), .ret_cnt(ret_cnt)
    );

    // Free-entry report: smaller of the two free counts, less the spare slot.
    always_comb begin
        int lqf, sqf, m;
        lqf = LQ_DEPTH + 1 - int'(lq_used);
        sqf = SLOTS - int'(count_q);
        m   = (lqf < sqf) ? lqf : sqf;
        free_slots = (m < 1) ? '0 : FREE_W'(m - 1);
    end

    // Pointer, count and per-slot flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            wb_q    <= '0;
            count_q <= '0;
            pend_q  <= '0;
            elig_q  <= '0;
            done_q  <= '0;
        end else begin
            head_q  <= IDX_W'(sq_pkg::ring_add(int'(head_q), int'(ret_cnt), SLOTS));
            if (squash_valid)
                tail_q <= IDX_W'(sq_pkg::ring_sub(int'(tail_q), int'(kill_cnt), SLOTS));
            else if (alloc_go)
                tail_q <= IDX_W'(sq_pkg::ring_add(int'(tail_q), 1, SLOTS));
            if (zero_done || accept)
                wb_q <= IDX_W'(sq_pkg::ring_add(int'(wb_q), 1, SLOTS));
            count_q <= CNT_W'(int'(count_q) + int'(alloc_go) - int'(ret_cnt) - int'(kill_cnt));
            pend_q  <= CNT_W'(int'(pend_q) + int'(mark_cnt) - int'(mem_cpl_valid) - int'(zero_done));
            for (int s = 0; s < SLOTS; s++) begin
                if (ret_vec[s]) begin
                    elig_q[s] <= 1'b0;
                    done_q[s] <= 1'b0;
                end else begin
                    if (mark[s])                  elig_q[s] <= 1'b1;
                    if (cpl_hit[s] || zero_hit[s]) done_q[s] <= 1'b1;
                end
                if (alloc_go && int'(tail_q) == s) begin
                    elig_q[s] <= 1'b0;
                    done_q[s] <= 1'b0;
                end
            end
        end
    end

    // Payload capture at the tail on allocation.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (alloc_go && int'(tail_q) == s) begin
                seq_q[s]  <= alloc_seq;
                size_q[s] <= alloc_size;
                addr_q[s] <= alloc_addr;
                data_q[s] <= alloc_data;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH); // R2

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= count_q); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !mem_cpl_valid
        |=> mem_req_valid && $stable(mem_req_idx) && $stable(mem_req_addr)); // R5

    AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> count_q <= $past(count_q)); // R11

    AST_HEAD_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cpl_valid && mem_cpl_idx == head_q && count_q != '0
        |=> head_q != $past(head_q)); // R7

endmodule

// File: tb/store_queue_test.sv
module store_queue_test;

    localparam int IDX_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [7:0]  alloc_seq = '0;
    logic [3:0]  alloc_size = '0;
    logic [15:0] alloc_addr = '0;
    logic [31:0] alloc_data = '0;
    logic        commit_valid = 1'b0;
    logic [7:0]  commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [7:0]  squash_seq = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [IDX_W-1:0] mem_req_idx;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic [3:0]  mem_req_size;
    logic        mem_cpl_valid = 1'b0;
    logic [IDX_W-1:0] mem_cpl_idx = '0;
    logic [2:0]  lq_used = '0;
    logic [2:0]  free_slots;

    int n_checks = 0;
    int n_fail   = 0;

    store_queue uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_size(alloc_size),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_idx(mem_req_idx), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_req_size(mem_req_size),
        .mem_cpl_valid(mem_cpl_valid), .mem_cpl_idx(mem_cpl_idx),
        .lq_used(lq_used), .free_slots(free_slots)
    );

    always #5 clk = ~clk;

    // Free-report vectors with an empty store queue: {lq_used, expected free}.
    localparam int NV = 4;
    localparam int FREE_VEC [NV][2] = '{'{0, 4}, '{3, 3}, '{5, 1}, '{6, 0}};

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        alloc_valid   = 1'b0;
        commit_valid  = 1'b0;
        squash_valid  = 1'b0;
        mem_cpl_valid = 1'b0;
    endtask

    task automatic put(input int seq, input int size, input int addr);
        alloc_valid = 1'b1;
        alloc_seq   = 8'(seq);
        alloc_size  = 4'(size);
        alloc_addr  = 16'(addr);
        alloc_data  = 32'(addr * 3 + 1);
        tick();
    endtask

    task automatic complete(input int idx);
        mem_cpl_valid = 1'b1;
        mem_cpl_idx   = IDX_W'(idx);
        tick();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 free after reset", int'(free_slots), 4);
        check("R1 no request after reset", int'(mem_req_valid), 0);

        // Fill: seq 10,20,30,40 in slots 0..3; slot 1 is zero-size.
        put(10, 4, 'h100);
        check("R2 free after one alloc", int'(free_slots), 3);
        put(20, 0, 'h104);
        put(30, 4, 'h108);
        put(40, 4, 'h10C);
        check("R2 free when full", int'(free_slots), 0);
        put(50, 4, 'h110);
        check("R2 alloc when full ignored", int'(free_slots), 0);
        check("R3 nothing requested before commit", int'(mem_req_valid), 0);

        // Commit up to 25: marks slots 0 and 1, stops at 30.
        commit_valid = 1'b1; commit_seq = 8'd25;
        tick();
        check("R4 request valid", int'(mem_req_valid), 1);
        check("R4 request index", int'(mem_req_idx), 0);
        check("R4 request address", int'(mem_req_addr), 'h100);
        check("R4 request data", int'(mem_req_data), 'h100 * 3 + 1);
        tick();
        check("R5 refused request held", int'(mem_req_valid), 1);
        check("R5 refused index stable", int'(mem_req_idx), 0);
        mem_req_ready = 1'b1;
        tick();
        check("R6 zero-size store not requested", int'(mem_req_valid), 0);
        tick();
        check("R3 uncommitted slot 2 not requested", int'(mem_req_valid), 0);
        check("R7 done entry behind head frees nothing", int'(free_slots), 0);
        complete(0);
        check("R7 head run of two retired", int'(free_slots), 2);

        // Same cycle: commit 30 (slot 2) and squash 25 (slot 3 removed only).
        commit_valid = 1'b1; commit_seq = 8'd30;
        squash_valid = 1'b1; squash_seq = 8'd25;
        tick();
        check("R9 squash removes one store", int'(free_slots), 3);
        check("R9 same-cycle committed store requested", int'(mem_req_valid), 1);
        check("R9 surviving slot index", int'(mem_req_idx), 2);
        tick();
        check("R8 squashed slot 3 never requested", int'(mem_req_valid), 0);

        // Allocation during a squash is ignored.
        squash_valid = 1'b1; squash_seq = 8'd55;
        alloc_valid = 1'b1; alloc_seq = 8'd60; alloc_size = 4'd4; alloc_addr = 16'h200;
        tick();
        check("R11 alloc during squash ignored", int'(free_slots), 3);
        complete(2);
        check("R7 queue empty after last completion", int'(free_slots), 4);

        // Squash stops at a committed store: slot 3 (70) committed, slot 4 (80) removed.
        put(70, 4, 'h300);
        put(80, 4, 'h304);
        check("R2 two stores held", int'(free_slots), 2);
        commit_valid = 1'b1; commit_seq = 8'd75;
        tick();
        check("R4 slot 3 requested", int'(mem_req_idx), 3);
        squash_valid = 1'b1; squash_seq = 8'd65;
        tick();
        check("R8 squash stops at committed store", int'(free_slots), 3);
        check("R8 removed slot 4 not requested", int'(mem_req_valid), 0);
        complete(3);
        check("R7 free after slot 3 completes", int'(free_slots), 4);

        // Wrap-around: slots 4 then 0, requested in order on successive cycles.
        put(90, 2, 'h400);
        put(95, 8, 'h404);
        commit_valid = 1'b1; commit_seq = 8'd99;
        tick();
        check("R4 first request at slot 4", int'(mem_req_idx), 4);
        check("R4 size carried", int'(mem_req_size), 2);
        tick();
        check("R4 wrapped request at slot 0", int'(mem_req_idx), 0);
        check("R4 wrapped request address", int'(mem_req_addr), 'h404);
        tick();
        check("R4 no request past tail", int'(mem_req_valid), 0);
        complete(0);
        check("R7 out-of-order completion held", int'(free_slots), 2);
        complete(4);
        check("R7 both retire on head completion", int'(free_slots), 4);

        // Free-report table walk with the store queue empty.
        for (int v = 0; v < NV; v++) begin
            lq_used = 3'(FREE_VEC[v][0]);
            #1;
            check("R10 free report min", int'(free_slots), FREE_VEC[v][1]);
        end
        lq_used = 3'd5;
        put(100, 4, 'h500);
        check("R10 load side limits report", int'(free_slots), 1);
        lq_used = 3'd0;
        #1;
        check("R10 store side limits report", int'(free_slots), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule